// File: doc/BRIEF.md
# Partitioned-Table Bit-Serial FIR Filter

This block is a four-tap finite impulse response filter that uses no multipliers. Each accepted two's complement sample is pushed into a short delay line. The block then walks the sample bits one per clock, starting at the most significant bit. In each cycle it takes the bit at the current position from every tap. These bits address a set of small precomputed tables. Each table word is the sum of the coefficients whose address bit is set. The table outputs are added together and fed into a doubling accumulator.

The address is split into several narrow tables instead of one wide table. With four taps and two partitions of two address bits each, the filter stores 8 words in place of 16. Coefficients are fixed at elaboration time through a packed parameter. The result keeps full precision and is neither rounded nor truncated.

A producer offers a sample with `in_valid` and the block takes it when `in_ready` is high. One result costs `SAMPLE_W` clock cycles. It is announced with a single-cycle `y_valid` pulse.

Top module: `da_fir_part`

## Requirements
- R1: `in_ready` is high exactly when the filter is idle and out of reset. A sample is taken on a rising edge where `in_valid` and `in_ready` are both high. In the following cycle `in_ready` is low.
- R2: `y_valid` is high for exactly one cycle, in the cycle that follows the `SAMPLE_W`-th rising edge after the accepting edge. It is low in every other cycle of that computation. `in_ready` is high again in the same cycle as `y_valid`.
- R3: While `y_valid` is high, `y_data` equals h0·x[n] + h1·x[n−1] + h2·x[n−2] + h3·x[n−3] as an `ACC_W`-bit two's complement number, where x[n] is the newest accepted sample. Coefficient h_k sits in `COEF_VEC[8k+7:8k]`. The defaults are h0=23, h1=−57, h2=127, h3=−128.
- R4: Reset clears the delay line to zero, so the first three results after reset treat older samples as zero.
- R5: Each partition table returns, for each address, the sum of the coefficients of the taps whose bits are set. A unit impulse followed by zeros therefore yields h0, h1, h2, h3 in turn, then 0.
- R6: The bit slice at the sign position is subtracted. Samples equal to −2^(SAMPLE_W−1) and other negative samples give correctly signed products.
- R7: The magnitude of `y_data` never exceeds (Σ|h_k|)·2^(SAMPLE_W−1). Extreme alternating samples produce the exact result with no wrap.
- R8: `in_valid` asserted while a computation is in progress is ignored. Neither the delay line nor the running result is altered.
- R9: While `rst_n` is low and for two cycles after it rises, `in_ready` and `y_valid` are low. After that, `in_ready` is high and `y_valid` is low until a sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A sample is offered |
| in_sample | input | SAMPLE_W | Two's complement input sample |
| in_ready | output | 1 | Filter idle, a sample may be taken |
| y_valid | output | 1 | One-cycle strobe marking a finished result |
| y_data | output | ACC_W | Full-precision two's complement result |

## Verification
A result appears in the cycle after the `SAMPLE_W`-th rising edge that follows the accepting edge. The bench drives and samples on falling edges. It counts `SAMPLE_W` falling edges after the one that follows acceptance and reads `y_valid` and `y_data` there. It also confirms that `y_valid` is low one falling edge before and one after. Synchronized reset release takes two cycles, and the bench waits past that before it checks the idle state.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  typedef enum logic {
    FIR_IDLE = 1'b0,
    FIR_RUN  = 1'b1
  } fir_state_e;

endpackage

// File: rtl/da_tap_line.sv
module da_tap_line #(
  parameter int NTAPS    = 4,
  parameter int SAMPLE_W = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               shift_en,
  input  logic [SAMPLE_W-1:0]                din,
  output logic [NTAPS-1:0][SAMPLE_W-1:0]     taps
);

  logic [NTAPS-1:0][SAMPLE_W-1:0] taps_q;
  logic [NTAPS-1:0][SAMPLE_W-1:0] taps_n;

  always_comb begin
    taps_n = taps_q;
    if (shift_en) begin
      taps_n[0] = din;
      for (int k = 1; k < NTAPS; k++) begin
        taps_n[k] = taps_q[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps_q <= '0;
    end else if (shift_en) begin
      taps_q <= taps_n;
    end
  end

  assign taps = taps_q;

endmodule

// File: rtl/da_part_lut.sv
module da_part_lut #(
  parameter int                  M      = 2,
  parameter int                  COEF_W = 8,
  parameter int                  PS_W   = 10,
  parameter logic [M*COEF_W-1:0] COEFS  = '0
) (
  input  logic [M-1:0]            addr,
  output logic signed [PS_W-1:0]  word
);

  localparam int WORDS = 2 ** M;

  function automatic logic signed [PS_W-1:0] sext_coef(input logic [COEF_W-1:0] c);
    return {{(PS_W-COEF_W){c[COEF_W-1]}}, c};
  endfunction

  function automatic logic signed [PS_W-1:0] word_value(input int a);
    logic signed [PS_W-1:0] s;
    s = '0;
    for (int m = 0; m < M; m++) begin
      if (((a >> m) & 1) == 1) begin
        s = s + sext_coef(COEFS[m*COEF_W +: COEF_W]);
      end
    end
    return s;
  endfunction

  logic signed [PS_W-1:0] table_w [WORDS];

  for (genvar a = 0; a < WORDS; a++) begin : g_word
    localparam logic signed [PS_W-1:0] WORD_VAL = word_value(a);
    assign table_w[a] = WORD_VAL;
  end

  assign word = table_w[addr];

endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc #(
  parameter int PS_W  = 10,
  parameter int ACC_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    sign_slice,
  input  logic signed [PS_W-1:0]  ps,
  output logic signed [ACC_W-1:0] acc
);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_n;
  logic signed [ACC_W-1:0] ps_ext;

  assign ps_ext = {{(ACC_W-PS_W){ps[PS_W-1]}}, ps};

  always_comb begin
    if (sign_slice) begin
      acc_n = -ps_ext;
    end else begin
      acc_n = {acc_q[ACC_W-2:0], 1'b0} + ps_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_n;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/da_fir_part.sv
module da_fir_part
  import da_fir_pkg::*;
#(
  parameter int                      NTAPS    = 4,
  parameter int                      PARTS    = 2,
  parameter int                      SAMPLE_W = 8,
  parameter int                      COEF_W   = 8,
  parameter logic [NTAPS*COEF_W-1:0] COEF_VEC = 32'h807F_C717,
  localparam int                     PS_W     = COEF_W + $clog2(NTAPS),
  localparam int                     ACC_W    = PS_W + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                in_ready,
  output logic                y_valid,
  output logic [ACC_W-1:0]    y_data
);

  localparam int M     = NTAPS / PARTS;
  localparam int BIT_W = (SAMPLE_W > 2) ? $clog2(SAMPLE_W) : 1;
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(SAMPLE_W - 1);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign srst_n = rst_sync_q[1];

  // control
  fir_state_e       state_q, state_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic             done_q, done_n;
  logic             accept;
  logic             running;

  assign in_ready = srst_n && (state_q == FIR_IDLE);
  assign accept   = in_valid && in_ready;
  assign running  = (state_q == FIR_RUN);

  always_comb begin
    state_n = state_q;
    bit_n   = bit_q;
    done_n  = 1'b0;
    unique case (state_q)
      FIR_IDLE: begin
        if (accept) begin
          state_n = FIR_RUN;
          bit_n   = TOP_BIT;
        end
      end
      FIR_RUN: begin
        if (bit_q == '0) begin
          state_n = FIR_IDLE;
          done_n  = 1'b1;
        end else begin
          bit_n = bit_q - BIT_W'(1);
        end
      end
      default: state_n = FIR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= FIR_IDLE;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      bit_q   <= bit_n;
      done_q  <= done_n;
    end
  end

  // delay line
  logic [NTAPS-1:0][SAMPLE_W-1:0] taps;

  da_tap_line #(
    .NTAPS   (NTAPS),
    .SAMPLE_W(SAMPLE_W)
  ) u_taps (
    .clk     (clk),
    .rst_n   (srst_n),
    .shift_en(accept),
    .din     (in_sample),
    .taps    (taps)
  );

  // one bit from every tap
  logic [NTAPS-1:0] slice;

  always_comb begin
    for (int k = 0; k < NTAPS; k++) begin
      slice[k] = taps[k][bit_q];
    end
  end

  // partitioned tables
  logic signed [PS_W-1:0] part_word [PARTS];

  for (genvar p = 0; p < PARTS; p++) begin : g_part
    da_part_lut #(
      .M     (M),
      .COEF_W(COEF_W),
      .PS_W  (PS_W),
      .COEFS (COEF_VEC[p*M*COEF_W +: M*COEF_W])
    ) u_lut (
      .addr(slice[p*M +: M]),
      .word(part_word[p])
    );
  end

  logic signed [PS_W-1:0] part_sum;

  always_comb begin
    part_sum = '0;
    for (int p = 0; p < PARTS; p++) begin
      part_sum = part_sum + part_word[p];
    end
  end

  // scaling accumulator, most significant slice first
  logic signed [ACC_W-1:0] acc;

  da_shift_acc #(
    .PS_W (PS_W),
    .ACC_W(ACC_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (srst_n),
    .en        (running),
    .sign_slice(bit_q == TOP_BIT),
    .ps        (part_sum),
    .acc       (acc)
  );

  assign y_valid = done_q;
  assign y_data  = acc;

endmodule

// File: rtl/da_fir_checker.sv
module da_fir_checker #(
  parameter int                      NTAPS    = 4,
  parameter int                      SAMPLE_W = 8,
  parameter int                      COEF_W   = 8,
  parameter int                      ACC_W    = 18,
  parameter logic [NTAPS*COEF_W-1:0] COEF_VEC = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             y_valid,
  input logic [ACC_W-1:0] y_data
);

  localparam int CNT_W = $clog2(SAMPLE_W + 2) + 1;
  localparam logic [CNT_W-1:0] DUE = CNT_W'(SAMPLE_W + 1);

  function automatic logic signed [ACC_W:0] calc_bound();
    logic signed [ACC_W:0] s;
    logic signed [ACC_W:0] c;
    s = '0;
    for (int k = 0; k < NTAPS; k++) begin
      c = {{(ACC_W+1-COEF_W){COEF_VEC[k*COEF_W+COEF_W-1]}}, COEF_VEC[k*COEF_W +: COEF_W]};
      if (c < 0) s = s - c;
      else       s = s + c;
    end
    return s <<< (SAMPLE_W - 1);
  endfunction

  localparam logic signed [ACC_W:0] BOUND = calc_bound();

  logic [CNT_W-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
    end else if (in_valid && in_ready) begin
      since_q <= CNT_W'(1);
    end else if (y_valid) begin
      since_q <= '0;
    end else if (since_q != '0 && since_q != '1) begin
      since_q <= since_q + CNT_W'(1);
    end
  end

  logic signed [ACC_W:0] y_ext;
  assign y_ext = {y_data[ACC_W-1], y_data};

  p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> (since_q == DUE));

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |=> !y_valid);

  p_ready_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> in_ready);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> ((y_ext <= BOUND) && (y_ext >= -BOUND)));

endmodule

bind da_fir_part da_fir_checker #(
  .NTAPS   (NTAPS),
  .SAMPLE_W(SAMPLE_W),
  .COEF_W  (COEF_W),
  .ACC_W   (ACC_W),
  .COEF_VEC(COEF_VEC)
) u_da_fir_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .y_valid (y_valid),
  .y_data  (y_data)
);

// File: tb/da_fir_part_bench.sv
module da_fir_part_bench;

  localparam int CLK_PERIOD = 10;
  localparam int L          = 8;
  localparam int ACC_W      = 18;
  localparam int H [4]      = '{23, -57, 127, -128};
  localparam int STIM [12]  = '{5, -3, 100, -128, 127, 0, -1, 64, -64, 17, -100, 1};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [L-1:0]     in_sample = '0;
  logic             in_ready;
  logic             y_valid;
  logic [ACC_W-1:0] y_data;

  int checks = 0;
  int failures = 0;
  int hist [4] = '{0, 0, 0, 0};
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  da_fir_part u_da_fir_part (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .in_ready (in_ready),
    .y_valid  (y_valid),
    .y_data   (y_data)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model_push(input int s);
    longint y = 0;
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = s;
    for (int k = 0; k < 4; k++) y += longint'(H[k]) * longint'(hist[k]);
    return y;
  endfunction

  // offer s; when hold is set, keep in_valid high with other data while busy
  task automatic send(input int s, input string req, input bit hold);
    longint exp;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_sample = s[L-1:0];
    @(negedge clk);
    exp = model_push(s);
    chk("R1", longint'(in_ready), 0);
    if (hold) in_sample = ~s[L-1:0];
    else      in_valid  = 1'b0;
    repeat (L-1) @(negedge clk);
    in_valid = 1'b0;
    chk("R2", longint'(y_valid), 0);
    @(negedge clk);
    chk("R2", longint'(y_valid), 1);
    chk("R2", longint'(in_ready), 1);
    chk(req, longint'($signed(y_data)), exp);
    @(negedge clk);
    chk("R2", longint'(y_valid), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", longint'(in_ready), 0);
    chk("R9", longint'(y_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", longint'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk("R9", longint'(in_ready), 1);
    chk("R9", longint'(y_valid), 0);
    for (int k = 0; k < 4; k++) hist[k] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();

    // R4: first outputs see zero history; table walk covers R3
    for (int i = 0; i < 12; i++) begin
      send(STIM[i], (i < 3) ? "R4" : "R3", 1'b0);
    end

    // R5: impulse response through the partitioned tables
    do_reset();
    send(1, "R5", 1'b0);
    for (int i = 0; i < 4; i++) send(0, "R5", 1'b0);

    // R6: sign-bit slice
    send(-128, "R6", 1'b0);
    send(-1, "R6", 1'b0);
    send(-128, "R6", 1'b0);
    send(-128, "R6", 1'b0);

    // R7: extremes of both signs
    send(127, "R7", 1'b0);
    send(-128, "R7", 1'b0);
    send(127, "R7", 1'b0);
    send(-128, "R7", 1'b0);
    send(-128, "R7", 1'b0);
    send(127, "R7", 1'b0);
    send(-128, "R7", 1'b0);
    send(127, "R7", 1'b0);

    // R8: in_valid held during a computation is ignored
    send(33, "R8", 1'b1);
    send(-77, "R8", 1'b1);
    send(12, "R8", 1'b0);

    // R4: reset in the middle of a computation clears the history
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 8'd90;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    do_reset();
    send(2, "R4", 1'b0);
    send(0, "R4", 1'b0);

    // R3: pseudo-random samples
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(int'($signed(lfsr[7:0])), "R3", 1'b0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule